// File: doc/BRIEF.md
# Eight-Bit Dual-Compare Timer

This block is an 8-bit up-counter with two compare constants, a control register and a status register. A byte-wide register bus gives access to all of them. The counter advances on a tick. The tick comes either from a free-running internal prescaler, at one of three division ratios, or from a chosen edge of an external clock pin, which first passes through a two-flop synchroniser. The counter can also be stopped.

A compare event is the cycle in which the counter becomes equal to a compare constant. Each event sets a sticky flag. An event can also clear the counter and can change the timer output pin. A rising edge on the external reset pin can clear the counter too. Wrapping from 0xFF to 0x00 sets an overflow flag. Each flag, gated by its own enable bit, drives an interrupt request pin.

The register bus is plain strobes with no back-pressure. A write takes effect at the clock edge where `bus_wr_i` is high. Read data is combinational from `bus_addr_i`. A read strobe (`bus_rd_i`) matters only to the flag-clearing protocol. There is no streaming data path, so no valid/ready interface is used.

Register addresses on `bus_addr_i`:
- 0: control
- 1: status
- 2: counter
- 3: compare constant A
- 4: compare constant B

Any other address reads 0x00 and ignores writes.

Top module: `tmr8_dual`

## Requirements
- R1: Control (addr 0), counter (addr 2), constant A (addr 3) and constant B (addr 4) read back the last value written. Status (addr 1) reads flag B in bit 7, flag A in bit 6, the overflow flag in bit 5, 0 in bit 4, output-select B in bits 3:2 and output-select A in bits 1:0. The output-select bits are plain read/write.
- R2: After reset, and on any cycle with `stby_i` high, the registers are initialised as follows: counter 0x00, both constants 0xFF, control 0x00, status 0x00, `tmo_o` low.
- R3: When the counter advances from 0xFF, it wraps to 0x00 and sets the overflow flag.
- R4: On the first cycle in which the counter equals constant A (or B), flag A (or flag B) is set one clock later. While the equality merely persists, no further event occurs.
- R5: Control bits 4:3 select clearing of the counter to 0x00:
  - 00: never cleared
  - 01: cleared on a compare A event
  - 10: cleared on a compare B event
  - 11: cleared on a synchronised rising edge of `ext_rst_i`
- R6: Output-select codes act on `tmo_o` at a compare event:
  - 00: leave it unchanged
  - 01: drive it low
  - 10: drive it high
  - 11: toggle it

  When events A and B occur in the same cycle, channel B's code alone applies.
- R7: Control bits 2:0 select the tick:
  - 000: the counter holds
  - 001: one tick every 2 clocks
  - 010: one tick every 8 clocks
  - 011: one tick every 32 clocks
- R8: Clock-select 100 counts synchronised rising edges of `ext_clk_i`. 101 counts falling edges. 110 and 111 count both edges.
- R9: A flag is cleared by writing 0 to its status bit only if the status register was read while that flag was 1. A write of 0 with no such read, or a write of 1, leaves the flag set. An event in the clearing cycle keeps the flag set.
- R10: Each interrupt request pin is high exactly when its flag is 1 and its enable bit is 1. The enables sit in control bit 7 for B, bit 6 for A and bit 5 for overflow.
- R11: A bus write to the counter loads the written value, taking priority over a tick or a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_i | input | 1 | Standby entry; re-initialises all registers |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (arms flag clearing) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| ext_clk_i | input | 1 | External count clock (asynchronous) |
| ext_rst_i | input | 1 | External counter clear (asynchronous) |
| tmo_o | output | 1 | Timer output pin |
| irq_cma_o | output | 1 | Compare A interrupt request |
| irq_cmb_o | output | 1 | Compare B interrupt request |
| irq_ovf_o | output | 1 | Overflow interrupt request |

## Verification
A wrong match-history bit shows at the status port one clock after a counter write. It shows either as a flag set without a new equality or as a missed flag, and `tmo_o` moves at the same edge. A wrong clear, wrap or tick decision appears in the counter readback within one tick period. That is two to 32 clocks for the internal sources, and about three clocks after an external edge for the synchronised sources. A wrong armed bit appears as a flag that survives, or vanishes on, the next status write.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int DW = 8;
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STS  = 3'd1;
  localparam logic [2:0] A_CNT  = 3'd2;
  localparam logic [2:0] A_CMPA = 3'd3;
  localparam logic [2:0] A_CMPB = 3'd4;
  localparam int NFLAG    = 3;  // 0 overflow, 1 compare A, 2 compare B
  localparam int FLAG_LSB = 5;  // status bit of flag 0

  typedef enum logic [1:0] {CLR_NONE, CLR_MA, CLR_MB, CLR_EXT} clr_sel_e;
  typedef enum logic [1:0] {OUT_KEEP, OUT_LOW, OUT_HIGH, OUT_TOGGLE} out_act_e;

  typedef struct packed {
    logic       ie_b;
    logic       ie_a;
    logic       ie_ovf;
    clr_sel_e   clr;
    logic [2:0] cks;
  } ctrl_t;
endpackage

// File: rtl/tmr8_sync_edge.sv
module tmr8_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl_o,
  output logic lvl_q_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign lvl_o   = sh[STAGES-1];
  assign lvl_q_o = sh[STAGES];
endmodule

// File: rtl/tmr8_tick_gen.sv
module tmr8_tick_gen #(
  parameter int TAP_A = 1,
  parameter int TAP_B = 3,
  parameter int TAP_C = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby,
  input  logic [2:0] cks,
  input  logic       ext_lvl,
  input  logic       ext_lvl_q,
  output logic       tick
);
  localparam int PRE_W = TAP_C;
  logic [PRE_W-1:0] pre;
  logic ext_rise, ext_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre <= '0;
    else if (stby) pre <= '0;
    else           pre <= pre + 1'b1;
  end

  assign ext_rise = ext_lvl & ~ext_lvl_q;
  assign ext_fall = ~ext_lvl & ext_lvl_q;

  always_comb begin
    unique case (cks)
      3'b001:          tick = &pre[TAP_A-1:0];
      3'b010:          tick = &pre[TAP_B-1:0];
      3'b011:          tick = &pre[TAP_C-1:0];
      3'b100:          tick = ext_rise;
      3'b101:          tick = ext_fall;
      3'b110, 3'b111:  tick = ext_rise | ext_fall;
      default:         tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr8_out.sv
module tmr8_out
  import tmr8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby,
  input  logic       ev_a,
  input  logic       ev_b,
  input  logic [1:0] os_a,
  input  logic [1:0] os_b,
  output logic       tmo
);
  out_act_e act;

  always_comb begin
    if (ev_b)      act = out_act_e'(os_b);
    else if (ev_a) act = out_act_e'(os_a);
    else           act = OUT_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tmo <= 1'b0;
    else if (stby) tmo <= 1'b0;
    else begin
      unique case (act)
        OUT_LOW:    tmo <= 1'b0;
        OUT_HIGH:   tmo <= 1'b1;
        OUT_TOGGLE: tmo <= ~tmo;
        default:    tmo <= tmo;
      endcase
    end
  end

  // R6: when both channels fire, channel B's low code wins over A
  p_b_priority_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_a && ev_b && os_b == 2'b01 && !stby) |=> !tmo);
  // R6: no event, no change
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_a && !ev_b && !stby) |=> $stable(tmo));
endmodule

// File: rtl/tmr8_dual.sv
module tmr8_dual
  import tmr8_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TAP_A = 1,
  parameter int TAP_B = 3,
  parameter int TAP_C = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_i,
  input  logic [2:0] bus_addr_i,
  input  logic       bus_wr_i,
  input  logic       bus_rd_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  input  logic       ext_clk_i,
  input  logic       ext_rst_i,
  output logic       tmo_o,
  output logic       irq_cma_o,
  output logic       irq_cmb_o,
  output logic       irq_ovf_o
);
  ctrl_t          ctrl;
  logic [DW-1:0]  cnt, cmp_a, cmp_b;
  logic [1:0]     os_a, os_b;
  logic [NFLAG-1:0] flag, armed, ev_vec, en_vec;
  logic match_a, match_b, match_a_q, match_b_q, ev_a, ev_b, ovf_ev;
  logic tick, clr_hit;
  logic xc_lvl, xc_lvl_q, xr_lvl, xr_lvl_q;
  logic wr_ctrl, wr_sts, wr_cnt, wr_a, wr_b, rd_sts;

  assign wr_ctrl = bus_wr_i && bus_addr_i == A_CTRL;
  assign wr_sts  = bus_wr_i && bus_addr_i == A_STS;
  assign wr_cnt  = bus_wr_i && bus_addr_i == A_CNT;
  assign wr_a    = bus_wr_i && bus_addr_i == A_CMPA;
  assign wr_b    = bus_wr_i && bus_addr_i == A_CMPB;
  assign rd_sts  = bus_rd_i && bus_addr_i == A_STS;

  tmr8_sync_edge #(.STAGES(SYNC_STAGES)) u_xclk (
    .clk(clk), .rst_n(rst_n), .din(ext_clk_i), .lvl_o(xc_lvl), .lvl_q_o(xc_lvl_q));
  tmr8_sync_edge #(.STAGES(SYNC_STAGES)) u_xrst (
    .clk(clk), .rst_n(rst_n), .din(ext_rst_i), .lvl_o(xr_lvl), .lvl_q_o(xr_lvl_q));

  tmr8_tick_gen #(.TAP_A(TAP_A), .TAP_B(TAP_B), .TAP_C(TAP_C)) u_tick (
    .clk(clk), .rst_n(rst_n), .stby(stby_i), .cks(ctrl.cks),
    .ext_lvl(xc_lvl), .ext_lvl_q(xc_lvl_q), .tick(tick));

  // compare events fire on the first cycle of equality
  assign match_a = cnt == cmp_a;
  assign match_b = cnt == cmp_b;
  assign ev_a    = match_a & ~match_a_q;
  assign ev_b    = match_b & ~match_b_q;

  always_comb begin
    unique case (ctrl.clr)
      CLR_MA:  clr_hit = ev_a;
      CLR_MB:  clr_hit = ev_b;
      CLR_EXT: clr_hit = xr_lvl & ~xr_lvl_q;
      default: clr_hit = 1'b0;
    endcase
  end

  assign ovf_ev = tick && cnt == {DW{1'b1}} && !wr_cnt && !clr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; cmp_a <= '1; cmp_b <= '1; ctrl <= '0;
      os_a <= '0; os_b <= '0; match_a_q <= 1'b0; match_b_q <= 1'b0;
    end else if (stby_i) begin
      cnt <= '0; cmp_a <= '1; cmp_b <= '1; ctrl <= '0;
      os_a <= '0; os_b <= '0; match_a_q <= 1'b0; match_b_q <= 1'b0;
    end else begin
      match_a_q <= match_a;
      match_b_q <= match_b;
      if (wr_cnt)       cnt <= bus_wdata_i;
      else if (clr_hit) cnt <= '0;
      else if (tick)    cnt <= cnt + 1'b1;
      if (wr_a)    cmp_a <= bus_wdata_i;
      if (wr_b)    cmp_b <= bus_wdata_i;
      if (wr_ctrl) ctrl  <= ctrl_t'(bus_wdata_i);
      if (wr_sts) begin
        os_b <= bus_wdata_i[3:2];
        os_a <= bus_wdata_i[1:0];
      end
    end
  end

  assign ev_vec = {ev_b, ev_a, ovf_ev};
  assign en_vec = {ctrl.ie_b, ctrl.ie_a, ctrl.ie_ovf};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic clr_req;
    assign clr_req = wr_sts && !bus_wdata_i[FLAG_LSB+i] && armed[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag[i] <= 1'b0; armed[i] <= 1'b0;
      end else if (stby_i) begin
        flag[i] <= 1'b0; armed[i] <= 1'b0;
      end else begin
        flag[i]  <= ev_vec[i] | (flag[i] & ~clr_req);
        armed[i] <= flag[i] & ~clr_req & (armed[i] | rd_sts);
      end
    end

    // R9: a set flag survives unless an armed clearing write arrives
    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !stby_i && !(wr_sts && armed[i])) |=> flag[i]);
  end

  assign irq_ovf_o = flag[0] & en_vec[0];
  assign irq_cma_o = flag[1] & en_vec[1];
  assign irq_cmb_o = flag[2] & en_vec[2];

  tmr8_out u_out (
    .clk(clk), .rst_n(rst_n), .stby(stby_i), .ev_a(ev_a), .ev_b(ev_b),
    .os_a(os_a), .os_b(os_b), .tmo(tmo_o));

  always_comb begin
    unique case (bus_addr_i)
      A_CTRL:  bus_rdata_o = ctrl;
      A_STS:   bus_rdata_o = {flag[2], flag[1], flag[0], 1'b0, os_b, os_a};
      A_CNT:   bus_rdata_o = cnt;
      A_CMPA:  bus_rdata_o = cmp_a;
      A_CMPB:  bus_rdata_o = cmp_b;
      default: bus_rdata_o = '0;
    endcase
  end

  // R11: a counter write wins over tick and clear
  p_cnt_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && !stby_i) |=> cnt == $past(bus_wdata_i));
  // R3: advancing from all-ones sets the overflow flag
  p_ovf_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == 8'hFF && !wr_cnt && !clr_hit && !stby_i) |=> (flag[0] && cnt == 8'h00));
  // R7: stopped counter holds its value
  p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.cks == 3'b000 && !wr_cnt && !clr_hit && !stby_i) |=> $stable(cnt));
  // R4: a compare A event sets flag A next clock
  p_match_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_a && !stby_i) |=> flag[1]);
endmodule

// File: tb/tmr8_dual_tb.sv
module tmr8_dual_tb;
  logic clk = 1'b0, rst_n = 1'b0, stby = 1'b0;
  logic [2:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic xclk = 1'b0, xrst = 1'b0;
  logic tmo, irq_a, irq_b, irq_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tmr8_dual u_dut (
    .clk(clk), .rst_n(rst_n), .stby_i(stby), .bus_addr_i(addr),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .ext_clk_i(xclk), .ext_rst_i(xrst), .tmo_o(tmo),
    .irq_cma_o(irq_a), .irq_cmb_o(irq_b), .irq_ovf_o(irq_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic xclk_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      xclk = 1'b1; wcyc(4); xclk = 1'b0; wcyc(4);
    end
    wcyc(4);
  endtask

  task automatic do_stby;
    @(negedge clk); stby = 1'b1; @(negedge clk); stby = 1'b0;
  endtask

  // expected flag after writing counter v: new equality only
  function automatic bit exp_flag(input logic [7:0] v, input logic [7:0] c, input logic [7:0] old);
    return (v == c) && (old != c);
  endfunction

  // expected pin after one event with a given output code
  function automatic bit exp_tmo(input logic [1:0] code, input bit prev);
    case (code)
      2'b01: return 1'b0;
      2'b10: return 1'b1;
      2'b11: return ~prev;
      default: return prev;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, a, b, v, old;
    int seed = 20240611;
    void'($urandom(seed));
    wcyc(3); rst_n = 1'b1; wcyc(2);

    // R2 reset values
    rreg(3'd0, d); chk(d == 8'h00, "R2 ctrl", d, 8'h00);
    rreg(3'd3, d); chk(d == 8'hFF, "R2 cmpA", d, 8'hFF);
    rreg(3'd4, d); chk(d == 8'hFF, "R2 cmpB", d, 8'hFF);
    rreg(3'd2, d); chk(d == 8'h00, "R2 cnt", d, 8'h00);
    rreg(3'd1, d); chk(d == 8'h00, "R2 sts", d, 8'h00);
    chk(tmo == 1'b0, "R2 tmo", tmo, 0);

    // R1 readback
    wreg(3'd3, 8'h5A); rreg(3'd3, d); chk(d == 8'h5A, "R1 cmpA", d, 8'h5A);
    wreg(3'd4, 8'hA5); rreg(3'd4, d); chk(d == 8'hA5, "R1 cmpB", d, 8'hA5);
    wreg(3'd0, 8'hE0); rreg(3'd0, d); chk(d == 8'hE0, "R1 ctrl", d, 8'hE0);
    wreg(3'd1, 8'h1B); rreg(3'd1, d); chk(d == 8'h0B, "R1 sts os bits", d, 8'h0B);
    rreg(3'd6, d); chk(d == 8'h00, "R1 unmapped", d, 8'h00);

    // R2 standby re-initialisation
    wreg(3'd2, 8'h33);
    do_stby;
    rreg(3'd3, d); chk(d == 8'hFF, "R2 stby cmpA", d, 8'hFF);
    rreg(3'd0, d); chk(d == 8'h00, "R2 stby ctrl", d, 8'h00);
    rreg(3'd2, d); chk(d == 8'h00, "R2 stby cnt", d, 8'h00);
    rreg(3'd1, d); chk(d == 8'h00, "R2 stby sts", d, 8'h00);

    // R7 stop and internal divisors
    wreg(3'd3, 8'h10); wreg(3'd4, 8'h10);
    wreg(3'd2, 8'h07); wcyc(20);
    rreg(3'd2, d); chk(d == 8'h07, "R7 stopped", d, 8'h07);
    wreg(3'd2, 8'h00); wreg(3'd0, 8'h01); wcyc(38); wreg(3'd0, 8'h00);
    rreg(3'd2, d); chk(d >= 19 && d <= 21, "R7 div2", d, 20);
    wreg(3'd2, 8'h00); wreg(3'd0, 8'h02); wcyc(78); wreg(3'd0, 8'h00);
    rreg(3'd2, d); chk(d >= 9 && d <= 11, "R7 div8", d, 10);
    wreg(3'd3, 8'hF0); wreg(3'd4, 8'hF0);
    wreg(3'd2, 8'h00); wreg(3'd0, 8'h03); wcyc(318); wreg(3'd0, 8'h00);
    rreg(3'd2, d); chk(d >= 9 && d <= 11, "R7 div32", d, 10);

    // R3 overflow, R10 gating
    do_stby; wreg(3'd3, 8'h10); wreg(3'd4, 8'h10);
    wreg(3'd2, 8'hFF); wreg(3'd0, 8'h21); wcyc(6); wreg(3'd0, 8'h20);
    rreg(3'd2, d); chk(d <= 8'h04, "R3 wrapped", d, 8'h02);
    rreg(3'd1, d); chk(d[5] == 1'b1, "R3 ovf flag", d[5], 1);
    chk(irq_o == 1'b1, "R10 ovf irq", irq_o, 1);
    wreg(3'd0, 8'h00); wcyc(1);
    chk(irq_o == 1'b0, "R10 ovf masked", irq_o, 0);

    // R8 external clock edges
    do_stby;
    wreg(3'd0, 8'h04); xclk_pulses(5);
    rreg(3'd2, d); chk(d == 8'd5, "R8 rising", d, 5);
    wreg(3'd2, 8'h00); wreg(3'd0, 8'h05); xclk_pulses(5);
    rreg(3'd2, d); chk(d == 8'd5, "R8 falling", d, 5);
    wreg(3'd2, 8'h00); wreg(3'd0, 8'h06); xclk_pulses(5);
    rreg(3'd2, d); chk(d == 8'd10, "R8 both", d, 10);
    wreg(3'd0, 8'h00);

    // R4/R5 compare events and clearing
    do_stby; wreg(3'd3, 8'h50); wreg(3'd4, 8'h60);
    wreg(3'd0, 8'h08); wreg(3'd2, 8'h50); wcyc(3);
    rreg(3'd2, d); chk(d == 8'h00, "R5 clear on A", d, 0);
    rreg(3'd1, d); chk(d[6] == 1'b1, "R4 flag A", d[6], 1);
    wreg(3'd0, 8'h10); wreg(3'd2, 8'h50); wcyc(3);
    rreg(3'd2, d); chk(d == 8'h50, "R5 no clear on A in B mode", d, 8'h50);
    wreg(3'd2, 8'h60); wcyc(3);
    rreg(3'd2, d); chk(d == 8'h00, "R5 clear on B", d, 0);
    rreg(3'd1, d); chk(d[7] == 1'b1, "R4 flag B", d[7], 1);
    wreg(3'd0, 8'h18); wreg(3'd2, 8'h40);
    xrst = 1'b1; wcyc(4); xrst = 1'b0; wcyc(4);
    rreg(3'd2, d); chk(d == 8'h00, "R5 ext clear", d, 0);
    wreg(3'd0, 8'h00); wreg(3'd2, 8'h40);
    xrst = 1'b1; wcyc(4); xrst = 1'b0; wcyc(4);
    rreg(3'd2, d); chk(d == 8'h40, "R5 ext ignored", d, 8'h40);

    // R9 clearing protocol
    do_stby; wreg(3'd3, 8'h22); wreg(3'd2, 8'h22); wcyc(2);
    wreg(3'd1, 8'h00);
    rreg(3'd1, d); chk(d[6] == 1'b1, "R9 no clear without read", d[6], 1);
    wreg(3'd1, 8'h40);
    rreg(3'd1, d); chk(d[6] == 1'b1, "R9 write one keeps", d[6], 1);
    wreg(3'd1, 8'h00);
    rreg(3'd1, d); chk(d[6] == 1'b0, "R9 cleared after read", d[6], 0);

    // R10 enables
    wreg(3'd4, 8'h22); wreg(3'd2, 8'h00); wreg(3'd2, 8'h22); wcyc(2);
    wreg(3'd0, 8'h40); wcyc(1);
    chk(irq_a == 1'b1, "R10 irq A", irq_a, 1);
    chk(irq_b == 1'b0, "R10 irq B masked", irq_b, 0);

    // R6 output selection and priority
    do_stby;
    wreg(3'd1, 8'h02); wreg(3'd3, 8'h11); wreg(3'd2, 8'h11); wcyc(2);
    chk(tmo == exp_tmo(2'b10, 1'b0), "R6 A high", tmo, 1);
    wreg(3'd1, 8'h06); wreg(3'd4, 8'h22); wreg(3'd2, 8'h22); wcyc(2);
    chk(tmo == exp_tmo(2'b01, 1'b1), "R6 B low", tmo, 0);
    wreg(3'd3, 8'h33); wreg(3'd4, 8'h33); wreg(3'd2, 8'h33); wcyc(2);
    chk(tmo == 1'b0, "R6 B priority", tmo, 0);
    wreg(3'd1, 8'h03); wreg(3'd3, 8'h44); wreg(3'd4, 8'h55);
    wreg(3'd2, 8'h44); wcyc(2);
    chk(tmo == exp_tmo(2'b11, 1'b0), "R6 toggle 1", tmo, 1);
    wreg(3'd2, 8'h00); wreg(3'd2, 8'h44); wcyc(2);
    chk(tmo == exp_tmo(2'b11, 1'b1), "R6 toggle 2", tmo, 0);

    // R11 write priority while counting at div2
    do_stby; wreg(3'd3, 8'h10); wreg(3'd4, 8'h10); wreg(3'd0, 8'h01);
    for (int i = 0; i < 12; i++) begin
      wcyc(i % 3);
      wreg(3'd2, 8'h80); rreg(3'd2, d);
      chk(d == 8'h80 || d == 8'h81, "R11 load wins", d, 8'h80);
    end

    // R4/R1 random compare patterns, counter stopped
    do_stby; old = 8'h00;
    for (int i = 0; i < 40; i++) begin
      a = 8'($urandom); b = 8'($urandom);
      wreg(3'd3, a); wreg(3'd4, b);
      rreg(3'd3, d); chk(d == a, "R1 random cmpA", d, a);
      rreg(3'd1, d); wreg(3'd1, 8'h00);
      rreg(3'd1, d); chk(d[7:5] == 3'b000, "R9 random clear", d, 0);
      case ($urandom % 4)
        0: v = a;
        1: v = b;
        default: v = 8'($urandom);
      endcase
      wreg(3'd2, v); wcyc(2);
      rreg(3'd1, d);
      chk(d[6] == exp_flag(v, a, old), "R4 random A", d[6], exp_flag(v, a, old));
      chk(d[7] == exp_flag(v, b, old), "R4 random B", d[7], exp_flag(v, b, old));
      old = v;
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule